// File: doc/BRIEF.md
# DS3 Receive Performance Error Accumulator

This block sits behind an aligned DS3 receive framer and counts performance errors. The framer gives it one received bit per clock, together with markers that say whether that bit is payload, a P-bit, a subframe-three C-bit, a subframe-four C-bit or the last bit of the frame. The framer also gives strobes for F-bit and M-bit mismatches and the out-of-frame (OOF) level. The block keeps four saturating counters:
- framing errors, of a selectable kind
- P-bit parity errors
- C-bit parity errors
- far-end block errors (FEBE)

Software reads the counters through a latch-and-clear strobe. That strobe moves every live counter into a holding register and restarts the live counts.

Parity is computed over the payload bits of one frame. It is then checked against the overhead bits of the frame that follows. The C-bit checks and the FEBE decode apply only when the block is in C-bit mode. In M23 mode those two counters stay idle. Each clock is one bit time, and frame boundaries come only from the frame-end marker.

Top module: `ds3_err_counters`

## Requirements
- R1: After reset the four holding outputs read zero, and a latch strobe issued before any error event returns zero on every output.
- R2: With `errType` = 2'b00 the framing counter counts OOF events: it adds one in each cycle where `oofLevel` is high and was low in the previous cycle, and nothing while the level stays high.
- R3: With `errType` = 2'b01 the framing counter adds one for each cycle with `fMiss` or `mMiss` high. With 2'b10 it counts only `fMiss`, and with 2'b11 only `mMiss`.
- R4: The even parity of all bits marked `payloadMark` in a frame is compared with every bit marked `pBitMark` in the next frame. If any of those bits differs, the P-bit counter adds exactly one, at that next frame's end.
- R5: In C-bit mode (`cbitMode` = 1) the same stored parity is compared with every bit marked `c3Mark` in the next frame. If any differs, the C-bit parity counter adds exactly one at that frame's end.
- R6: In C-bit mode the bits marked `c4Mark` in a frame form the FEBE code. If all of them are 1 (code 111) nothing is counted; otherwise the FEBE counter adds exactly one at that frame's end.
- R7: With `cbitMode` = 0 (M23) the C-bit parity and FEBE counters never increment.
- R8: A frame is complete when it starts at a frame end and runs to the next one with `oofLevel` low throughout. Parity is checked only in a complete frame whose previous frame was also complete. So after reset or after OOF, the first complete frame makes no parity comparison.
- R9: Each counter is 16 bits wide and holds at 65535 instead of wrapping.
- R10: A cycle with `latchReq` high copies every live counter to its output register. The same cycle clears the live counters, and any increment that happens in that cycle becomes the first count of the new interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one received bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cbitMode | input | 1 | 1 = C-bit format, 0 = M23 format |
| errType | input | 2 | Framing error kind: 00 OOF events, 01 F or M, 10 F only, 11 M only |
| oofLevel | input | 1 | Out-of-frame level from the framer |
| rxBit | input | 1 | Received bit for this cycle |
| payloadMark | input | 1 | rxBit is a payload bit |
| pBitMark | input | 1 | rxBit is a P-bit |
| c3Mark | input | 1 | rxBit is a subframe-three C-bit |
| c4Mark | input | 1 | rxBit is a subframe-four C-bit |
| frameEnd | input | 1 | rxBit is the last bit of the frame |
| fMiss | input | 1 | An F-bit mismatch was seen this cycle |
| mMiss | input | 1 | An M-bit mismatch was seen this cycle |
| latchReq | input | 1 | Latch the counters to the outputs and clear them |
| frmErrCnt | output | 16 | Latched framing error count |
| pParErrCnt | output | 16 | Latched P-bit parity error count |
| cParErrCnt | output | 16 | Latched C-bit parity error count |
| febeErrCnt | output | 16 | Latched FEBE error count |

## Verification
The hardest case to reach is the parity check across a frame boundary: it needs a stored reference from a complete frame. Right after reset, or right after an OOF episode, that reference is missing. The stimulus therefore sends two priming frames before the vector table and tracks the payload parity of each vector's frame in the next vector's expected result. The OOF case replays this with deliberately wrong P-bits in the two frames after OOF clears; no count is expected until the third frame. Saturation is reached by holding the F-mismatch strobe for more than 65535 cycles with no latch in between.

// File: rtl/ds3_err_pkg.sv
package ds3_err_pkg;

  // Framing error kind selected by errType
  typedef enum logic [1:0] {
    ERR_OOF   = 2'b00,
    ERR_FM    = 2'b01,
    ERR_FONLY = 2'b10,
    ERR_MONLY = 2'b11
  } err_sel_e;

  localparam int NUM_CNT  = 4;
  localparam int CNT_FRM  = 0;
  localparam int CNT_PAR  = 1;
  localparam int CNT_CPAR = 2;
  localparam int CNT_FEBE = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic               latch;
    logic [NUM_CNT-1:0] inc;
  } strobe_t;

endpackage

// File: rtl/ds3_sat_cnt.sv
module ds3_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      // restart interval; an event in this cycle is kept
      cnt <= inc ? CNT_ONE : '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + CNT_ONE;
    end
  end
endmodule

// File: rtl/ds3_err_ctrl.sv
module ds3_err_ctrl
  import ds3_err_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cbitMode,
  input  logic [1:0] errType,
  input  logic       oofLevel,
  input  logic       rxBit,
  input  logic       payloadMark,
  input  logic       pBitMark,
  input  logic       c3Mark,
  input  logic       c4Mark,
  input  logic       frameEnd,
  input  logic       fMiss,
  input  logic       mMiss,
  input  logic       latchReq,
  output strobe_t    strb
);
  err_sel_e errSel;
  logic oofPrev;
  logic oofRise;
  logic frmHit;

  logic runParity;
  logic refParity;
  logic refValid;
  logic cleanFrame;
  logic pBad, c3Bad, febeBad;
  logic pBadNow, c3BadNow, febeBadNow;
  logic frameParity;
  logic frameOk;

  assign errSel  = err_sel_e'(errType);
  assign oofRise = oofLevel & ~oofPrev;

  always_comb begin
    unique case (errSel)
      ERR_OOF:   frmHit = oofRise;
      ERR_FM:    frmHit = fMiss | mMiss;
      ERR_FONLY: frmHit = fMiss;
      ERR_MONLY: frmHit = mMiss;
      default:   frmHit = 1'b0;
    endcase
  end

  // Per-frame evaluation including the current bit
  assign frameParity = runParity ^ (payloadMark & rxBit);
  assign pBadNow     = pBad    | (pBitMark & (rxBit ^ refParity));
  assign c3BadNow    = c3Bad   | (c3Mark   & (rxBit ^ refParity));
  assign febeBadNow  = febeBad | (c4Mark   & ~rxBit);
  assign frameOk     = frameEnd & cleanFrame & ~oofLevel;

  always_comb begin
    strb                = '0;
    strb.latch          = latchReq;
    strb.inc[CNT_FRM]   = frmHit;
    strb.inc[CNT_PAR]   = frameOk & refValid & pBadNow;
    strb.inc[CNT_CPAR]  = frameOk & refValid & cbitMode & c3BadNow;
    strb.inc[CNT_FEBE]  = frameOk & cbitMode & febeBadNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oofPrev    <= 1'b0;
      runParity  <= 1'b0;
      refParity  <= 1'b0;
      refValid   <= 1'b0;
      cleanFrame <= 1'b0;
      pBad       <= 1'b0;
      c3Bad      <= 1'b0;
      febeBad    <= 1'b0;
    end else begin
      oofPrev <= oofLevel;
      if (frameEnd) begin
        runParity  <= 1'b0;
        refParity  <= frameParity;
        refValid   <= frameOk;
        cleanFrame <= ~oofLevel;
        pBad       <= 1'b0;
        c3Bad      <= 1'b0;
        febeBad    <= 1'b0;
      end else begin
        runParity <= frameParity;
        pBad      <= pBadNow;
        c3Bad     <= c3BadNow;
        febeBad   <= febeBadNow;
        if (oofLevel) begin
          cleanFrame <= 1'b0;
          refValid   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ds3_err_dpath.sv
module ds3_err_dpath
  import ds3_err_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strb,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   liveCnt,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   heldCnt
);
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    ds3_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (strb.latch),
      .inc  (strb.inc[k]),
      .cnt  (liveCnt[k])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        heldCnt[k] <= '0;
      end else if (strb.latch) begin
        heldCnt[k] <= liveCnt[k];
      end
    end
  end
endmodule

// File: rtl/ds3_err_counters.sv
module ds3_err_counters
  import ds3_err_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cbitMode,
  input  logic [1:0]       errType,
  input  logic             oofLevel,
  input  logic             rxBit,
  input  logic             payloadMark,
  input  logic             pBitMark,
  input  logic             c3Mark,
  input  logic             c4Mark,
  input  logic             frameEnd,
  input  logic             fMiss,
  input  logic             mMiss,
  input  logic             latchReq,
  output logic [CNT_W-1:0] frmErrCnt,
  output logic [CNT_W-1:0] pParErrCnt,
  output logic [CNT_W-1:0] cParErrCnt,
  output logic [CNT_W-1:0] febeErrCnt
);
  strobe_t                       strb;
  logic [NUM_CNT-1:0][CNT_W-1:0] liveCnt;
  logic [NUM_CNT-1:0][CNT_W-1:0] heldCnt;

  ds3_err_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cbitMode    (cbitMode),
    .errType     (errType),
    .oofLevel    (oofLevel),
    .rxBit       (rxBit),
    .payloadMark (payloadMark),
    .pBitMark    (pBitMark),
    .c3Mark      (c3Mark),
    .c4Mark      (c4Mark),
    .frameEnd    (frameEnd),
    .fMiss       (fMiss),
    .mMiss       (mMiss),
    .latchReq    (latchReq),
    .strb        (strb)
  );

  ds3_err_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .liveCnt (liveCnt),
    .heldCnt (heldCnt)
  );

  assign frmErrCnt  = heldCnt[CNT_FRM];
  assign pParErrCnt = heldCnt[CNT_PAR];
  assign cParErrCnt = heldCnt[CNT_CPAR];
  assign febeErrCnt = heldCnt[CNT_FEBE];
endmodule

// File: rtl/ds3_err_checker.sv
module ds3_err_checker
  import ds3_err_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cbitMode,
  input logic [1:0]                    errType,
  input logic                          oofLevel,
  input logic                          frameEnd,
  input logic                          latchReq,
  input strobe_t                       strb,
  input logic [NUM_CNT-1:0][CNT_W-1:0] liveCnt
);
  // R2: an OOF-mode framing count only while OOF is high
  assert_oof_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((errType == 2'b00) && strb.inc[CNT_FRM]) |-> oofLevel);

  // R2: never two OOF events in back-to-back cycles
  assert_oof_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((errType == 2'b00) && strb.inc[CNT_FRM]) |=> !((errType == 2'b00) && strb.inc[CNT_FRM]));

  // R4: per-frame counters move only on the frame end
  assert_frame_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc[CNT_PAR] || strb.inc[CNT_CPAR] || strb.inc[CNT_FEBE]) |-> frameEnd);

  // R7: M23 keeps C-bit parity and FEBE quiet
  assert_m23_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cbitMode |-> !(strb.inc[CNT_CPAR] || strb.inc[CNT_FEBE]));

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
    // R10: after a latch a live counter holds at most the latch-cycle event
    assert_latch_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
      latchReq |=> (liveCnt[k] <= CNT_W'(1)));

    // R9: a full counter stays full until latched
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
      ((&liveCnt[k]) && !latchReq) |=> (&liveCnt[k]));
  end
endmodule

bind ds3_err_counters ds3_err_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cbitMode (cbitMode),
  .errType  (errType),
  .oofLevel (oofLevel),
  .frameEnd (frameEnd),
  .latchReq (latchReq),
  .strb     (strb),
  .liveCnt  (liveCnt)
);

// File: tb/ds3_err_counters_tb.sv
module ds3_err_counters_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cbitMode = 1'b1;
  logic [1:0] errType = 2'b00;
  logic oofLevel = 1'b0;
  logic rxBit = 1'b0;
  logic payloadMark = 1'b0, pBitMark = 1'b0, c3Mark = 1'b0, c4Mark = 1'b0;
  logic frameEnd = 1'b0, fMiss = 1'b0, mMiss = 1'b0, latchReq = 1'b0;
  logic [CNT_W-1:0] frmErrCnt, pParErrCnt, cParErrCnt, febeErrCnt;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;  // 125 MHz

  ds3_err_counters #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .cbitMode(cbitMode), .errType(errType),
    .oofLevel(oofLevel), .rxBit(rxBit), .payloadMark(payloadMark),
    .pBitMark(pBitMark), .c3Mark(c3Mark), .c4Mark(c4Mark),
    .frameEnd(frameEnd), .fMiss(fMiss), .mMiss(mMiss), .latchReq(latchReq),
    .frmErrCnt(frmErrCnt), .pParErrCnt(pParErrCnt),
    .cParErrCnt(cParErrCnt), .febeErrCnt(febeErrCnt)
  );

  typedef struct packed {
    logic       cbit;
    logic [1:0] sel;
    logic [7:0] payload;
    logic [1:0] pBits;
    logic [2:0] c3;
    logic [2:0] c4;
    logic [1:0] nF;
    logic [1:0] nM;
    logic [2:0] eFrm;
    logic       ePar;
    logic       eCpar;
    logic       eFebe;
  } vec_t;

  // Expected parity results refer to the previous row's payload parity.
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'b01, 8'h01, 2'b00, 3'b000, 3'b111, 2'd2, 2'd1, 3'd3, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'b10, 8'h03, 2'b11, 3'b111, 3'b111, 2'd2, 2'd1, 3'd2, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'b11, 8'h07, 2'b01, 3'b000, 3'b110, 2'd3, 2'd2, 3'd2, 1'b1, 1'b0, 1'b1},
    '{1'b1, 2'b01, 8'h00, 2'b11, 3'b101, 3'b000, 2'd0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1},
    '{1'b0, 2'b10, 8'h0F, 2'b11, 3'b111, 3'b000, 2'd1, 2'd3, 3'd1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 2'b11, 8'h01, 2'b00, 3'b000, 3'b111, 2'd0, 2'd3, 3'd3, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'b00, 8'hFF, 2'b10, 3'b110, 3'b011, 2'd2, 2'd2, 3'd0, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {payloadMark, pBitMark, c3Mark, c4Mark, frameEnd, fMiss, mMiss, latchReq, rxBit} = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // One latch cycle; outputs are read at the next falling edge.
  task automatic doLatch();
    idle(); latchReq = 1'b1; step(); latchReq = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] payload, input logic [1:0] pBits,
                           input logic [2:0] c3, input logic [2:0] c4,
                           input int nF, input int nM);
    for (int i = 0; i < 2; i++) begin idle(); pBitMark = 1'b1; rxBit = pBits[i]; step(); end
    for (int i = 0; i < 3; i++) begin idle(); c3Mark = 1'b1; rxBit = c3[i]; step(); end
    for (int i = 0; i < 3; i++) begin idle(); c4Mark = 1'b1; rxBit = c4[i]; step(); end
    for (int i = 0; i < nF; i++) begin idle(); fMiss = 1'b1; step(); end
    for (int i = 0; i < nM; i++) begin idle(); mMiss = 1'b1; step(); end
    for (int i = 0; i < 8; i++) begin
      idle(); payloadMark = 1'b1; rxBit = payload[i]; frameEnd = (i == 7); step();
    end
    idle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin : main
    idle();
    repeat (3) step();
    rstN = 1'b1;
    step();
    check("R1", "frm after reset", frmErrCnt, 0);
    check("R1", "par after reset", pParErrCnt, 0);
    doLatch();
    check("R1", "frm empty latch", frmErrCnt, 0);
    check("R1", "cpar empty latch", cParErrCnt, 0);
    check("R1", "febe empty latch", febeErrCnt, 0);

    // priming: boundary frame then reference frame with even parity
    cbitMode = 1'b1; errType = 2'b00;
    sendFrame(8'h00, 2'b11, 3'b111, 3'b111, 0, 0);
    sendFrame(8'h00, 2'b11, 3'b111, 3'b111, 0, 0);
    doLatch();
    check("R8", "par with no reference", pParErrCnt, 0);

    // table: R3 framing kinds, R4 P parity, R5 C parity, R6 FEBE, R7 M23
    for (int v = 0; v < NVEC; v++) begin
      cbitMode = VECS[v].cbit;
      errType  = VECS[v].sel;
      sendFrame(VECS[v].payload, VECS[v].pBits, VECS[v].c3, VECS[v].c4,
                int'(VECS[v].nF), int'(VECS[v].nM));
      doLatch();
      check("R3", $sformatf("vec%0d frm", v), frmErrCnt, CNT_W'(VECS[v].eFrm));
      check("R4", $sformatf("vec%0d par", v), pParErrCnt, CNT_W'(VECS[v].ePar));
      check(VECS[v].cbit ? "R5" : "R7", $sformatf("vec%0d cpar", v), cParErrCnt, CNT_W'(VECS[v].eCpar));
      check(VECS[v].cbit ? "R6" : "R7", $sformatf("vec%0d febe", v), febeErrCnt, CNT_W'(VECS[v].eFebe));
    end

    // R2 and R8: two OOF episodes, then frames with wrong P-bits
    cbitMode = 1'b1; errType = 2'b00;
    oofLevel = 1'b1; repeat (3) step();
    oofLevel = 1'b0; repeat (2) step();
    oofLevel = 1'b1; repeat (3) step();
    oofLevel = 1'b0; step();
    sendFrame(8'h00, 2'b11, 3'b000, 3'b111, 0, 0);
    sendFrame(8'h00, 2'b11, 3'b000, 3'b111, 0, 0);
    doLatch();
    check("R2", "oof events", frmErrCnt, 2);
    check("R8", "par first frame after oof", pParErrCnt, 0);
    sendFrame(8'h00, 2'b11, 3'b000, 3'b111, 0, 0);
    doLatch();
    check("R8", "par resumes", pParErrCnt, 1);
    check("R2", "no oof event", frmErrCnt, 0);

    // R10: event in the latch cycle lands in the new interval
    errType = 2'b01;
    for (int i = 0; i < 4; i++) begin idle(); fMiss = 1'b1; step(); end
    idle(); fMiss = 1'b1; latchReq = 1'b1; step(); idle();
    check("R10", "held before latch event", frmErrCnt, 4);
    doLatch();
    check("R10", "latch-cycle event kept", frmErrCnt, 1);

    // R9: saturation
    idle(); fMiss = 1'b1;
    repeat (65600) step();
    idle();
    doLatch();
    check("R9", "frm saturates", frmErrCnt, 16'hFFFF);
    doLatch();
    check("R10", "cleared after latch", frmErrCnt, 0);

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule